// File: doc/BRIEF.md
# Pseudoslot Address Decoder

This block sits between a host processor's address bus and a card mapped into one pseudoslot of a slotted address map. On each bus clock it looks at the upper address bits, the active-low address strobe, the read/write line, the addressing-mode flag and the configured slot number. It then drives four registered active-low selects: a coarse expansion-space qualifier, and three card selects for the declaration ROM, the control registers and the framebuffer.

The coarse qualifier covers the whole expansion region, and on-board video also answers inside that region. A card select therefore asserts only when the qualifier and a complete decode of the card's own window both match. In 32-bit mode the window is 16 MB. In 24-bit mode it is 1 MB, and the upper address byte is ignored.

Only address bits 31:16 enter the block, because bits below 16 never change which region is selected. The decoded region is held in a small state register with four states:
- `RG_IDLE`: no card select.
- `RG_FB`: framebuffer.
- `RG_CTRL`: control registers.
- `RG_ROM`: declaration ROM.

Every clock edge takes one of these transitions:
- Go to `RG_IDLE` when the strobe is high, when the qualifier or the window misses, when the slot number is invalid, or on a write to the ROM region.
- Go to `RG_ROM` on a read that hits the ROM region.
- Go to `RG_CTRL` on an access that hits the control region.
- Go to `RG_FB` on an access that hits anywhere else in the window.

Reset forces `RG_IDLE`.

Top module: `pslot_decoder`

## Requirements
- R1: While reset is asserted, all four outputs are high.
- R2: In 32-bit mode (mode32=1), `space_n` is low in the cycle after a clock edge that samples the strobe low with address bits 31:28 at 6 or above. It is high when those bits are below 6.
- R3: In 24-bit mode (mode32=0), the qualifier uses address bits 23:20 (at 6 or above), and bits 31:24 have no effect on it.
- R4: A clock edge that samples the strobe high drives all four outputs high in the following cycle.
- R5: In 32-bit mode, the card window matches only when address bits 31:28 equal the slot number and bits 27:24 are zero. Any other upper byte gives no card select, so the window has no alias.
- R6: In 24-bit mode, the card window matches when address bits 23:20 equal the slot number, whatever bits 31:24 hold.
- R7: A read whose in-window offset lies in the top 64 KB drives `rom_sel_n` low. In 32-bit mode that is offset 0xFF0000 to 0xFFFFFF; in 24-bit mode it is 0xF0000 to 0xFFFFF.
- R8: An access to the 64 KB just below the ROM drives `ctl_sel_n` low. In 32-bit mode that is offset 0xFE0000 to 0xFEFFFF; in 24-bit mode it is 0xE0000 to 0xEFFFF.
- R9: An access to any other in-window offset, from offset 0 upward, drives `fb_sel_n` low.
- R10: A write (rd_wr=0) to the ROM region asserts no card select; the qualifier still follows R2 and R3.
- R11: With the slot number outside 9 to 14, no card select asserts.
- R12: At most one card select is low at a time, and a card select is low only while `space_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| haddr_hi | input | 16 | Host address bits 31:16 |
| as_n | input | 1 | Active-low address strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| mode32 | input | 1 | 1 = 32-bit addressing, 0 = 24-bit |
| slot_id | input | 4 | Configured pseudoslot number |
| space_n | output | 1 | Expansion-space qualifier, active low |
| rom_sel_n | output | 1 | Declaration ROM select, active low |
| ctl_sel_n | output | 1 | Control-register select, active low |
| fb_sel_n | output | 1 | Framebuffer select, active low |

## Verification
The bench targets the region edges in both modes: the last framebuffer offset against the first control offset, and the last control offset against the first ROM offset. A design with an off-by-one sub-region compare would return the wrong select at exactly these addresses. It also targets an upper byte that differs from the window only in bits 27:24; a decoder that skipped those bits would respond there as an alias and could clash with on-board video. Finally, it applies 24-bit accesses with garbage in the top byte, where a decoder that did not mask those bits would drop the card. It also covers ROM writes, slot numbers just outside the legal range, and the qualifier threshold at 0x5FFF/0x6000, where a wrong compare would move the expansion-space edge.

// File: rtl/pslot_pkg.sv
package pslot_pkg;

    // Decoded card region held in the state register
    typedef enum logic [1:0] {
        RG_IDLE = 2'd0,
        RG_FB   = 2'd1,
        RG_CTRL = 2'd2,
        RG_ROM  = 2'd3
    } region_e;

    // Sub-region of a matched window, before the read/write rule is applied
    typedef enum logic [1:0] {
        ZN_FB   = 2'd0,
        ZN_CTRL = 2'd1,
        ZN_ROM  = 2'd2
    } zone_e;

endpackage

// File: rtl/pslot_qual.sv
module pslot_qual #(
    parameter logic [3:0] QUAL_NIB = 4'h6
) (
    input  logic [3:0] nib_hi32,   // address bits 31:28
    input  logic [3:0] nib_hi24,   // address bits 23:20
    input  logic       mode32,
    output logic       in_space
);
    always_comb begin
        if (mode32) in_space = (nib_hi32 >= QUAL_NIB);
        else        in_space = (nib_hi24 >= QUAL_NIB);
    end
endmodule

// File: rtl/pslot_slot_guard.sv
module pslot_slot_guard #(
    parameter logic [3:0] SLOT_LO = 4'h9,
    parameter logic [3:0] SLOT_HI = 4'hE
) (
    input  logic [3:0] slot_id,
    output logic       slot_ok
);
    assign slot_ok = (slot_id >= SLOT_LO) && (slot_id <= SLOT_HI);
endmodule

// File: rtl/pslot_window.sv
module pslot_window #(
    parameter int ADDR_W   = 32,
    parameter int SUB_AW   = 16,
    parameter int WIN32_AW = 24,
    parameter int WIN24_AW = 20
) (
    input  logic [ADDR_W-1:SUB_AW] addr_hi,
    input  logic                   mode32,
    input  logic [3:0]             slot,
    output logic                   hit,
    output pslot_pkg::zone_e       zone
);
    import pslot_pkg::*;

    localparam int MODES = 2;   // index 0: 24-bit, index 1: 32-bit

    logic [MODES-1:0] hit_m;
    logic [MODES-1:0] rom_m;
    logic [MODES-1:0] ctl_m;

    for (genvar m = 0; m < MODES; m++) begin : g_mode
        localparam int AW = (m == 1) ? WIN32_AW : WIN24_AW;
        localparam int TW = AW - SUB_AW;
        logic [TW-1:0] top;

        assign top      = addr_hi[AW-1:SUB_AW];
        assign rom_m[m] = &top;
        assign ctl_m[m] = (top == {{(TW-1){1'b1}}, 1'b0});

        if (m == 1) begin : g_w32
            assign hit_m[m] = (addr_hi[ADDR_W-1:ADDR_W-4] == slot) &&
                              (addr_hi[ADDR_W-5:AW] == '0);
        end else begin : g_w24
            assign hit_m[m] = (addr_hi[AW+3:AW] == slot);
        end
    end

    always_comb begin
        hit = hit_m[mode32];
        if (rom_m[mode32])      zone = ZN_ROM;
        else if (ctl_m[mode32]) zone = ZN_CTRL;
        else                    zone = ZN_FB;
    end
endmodule

// File: rtl/pslot_decoder.sv
module pslot_decoder #(
    parameter int         ADDR_W   = 32,
    parameter int         SUB_AW   = 16,
    parameter logic [3:0] QUAL_NIB = 4'h6,
    parameter logic [3:0] SLOT_LO  = 4'h9,
    parameter logic [3:0] SLOT_HI  = 4'hE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:SUB_AW] haddr_hi,
    input  logic                   as_n,
    input  logic                   rd_wr,
    input  logic                   mode32,
    input  logic [3:0]             slot_id,
    output logic                   space_n,
    output logic                   rom_sel_n,
    output logic                   ctl_sel_n,
    output logic                   fb_sel_n
);
    import pslot_pkg::*;

    localparam int WIN32_AW = ADDR_W - 8;
    localparam int WIN24_AW = WIN32_AW - 4;

    logic    in_space;
    logic    slot_ok;
    logic    win_hit;
    zone_e   zone;
    region_e region_d;
    region_e region_q;
    logic    space_q;

    pslot_qual #(.QUAL_NIB(QUAL_NIB)) u_qual (
        .nib_hi32 (haddr_hi[ADDR_W-1:ADDR_W-4]),
        .nib_hi24 (haddr_hi[WIN32_AW-1:WIN32_AW-4]),
        .mode32   (mode32),
        .in_space (in_space)
    );

    pslot_slot_guard #(.SLOT_LO(SLOT_LO), .SLOT_HI(SLOT_HI)) u_guard (
        .slot_id (slot_id),
        .slot_ok (slot_ok)
    );

    pslot_window #(
        .ADDR_W(ADDR_W), .SUB_AW(SUB_AW),
        .WIN32_AW(WIN32_AW), .WIN24_AW(WIN24_AW)
    ) u_win (
        .addr_hi (haddr_hi),
        .mode32  (mode32),
        .slot    (slot_id),
        .hit     (win_hit),
        .zone    (zone)
    );

    // Next region: qualifier AND full window decode AND legal slot
    always_comb begin
        region_d = RG_IDLE;
        if (!as_n && in_space && slot_ok && win_hit) begin
            unique case (zone)
                ZN_ROM:  region_d = rd_wr ? RG_ROM : RG_IDLE;
                ZN_CTRL: region_d = RG_CTRL;
                ZN_FB:   region_d = RG_FB;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= RG_IDLE;
            space_q  <= 1'b0;
        end else begin
            region_q <= region_d;
            space_q  <= !as_n && in_space;
        end
    end

    // Outputs from registered state
    always_comb begin
        rom_sel_n = 1'b1;
        ctl_sel_n = 1'b1;
        fb_sel_n  = 1'b1;
        unique case (region_q)
            RG_IDLE: ;
            RG_FB:   fb_sel_n  = 1'b0;
            RG_CTRL: ctl_sel_n = 1'b0;
            RG_ROM:  rom_sel_n = 1'b0;
        endcase
    end
    assign space_n = !space_q;

    // R12
    card_needs_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_sel_n || !ctl_sel_n || !fb_sel_n) |-> !space_n);

    // R4
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (space_n && rom_sel_n && ctl_sel_n && fb_sel_n));

    // R10
    rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !rd_wr) |=> rom_sel_n);

    // R11
    bad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_id < SLOT_LO || slot_id > SLOT_HI) |=> (rom_sel_n && ctl_sel_n && fb_sel_n));

    // R2
    space32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && mode32 && haddr_hi[ADDR_W-1:ADDR_W-4] >= QUAL_NIB) |=> !space_n);
endmodule

// File: tb/tb_pslot_decoder.sv
module tb_pslot_decoder;

    typedef struct {
        logic [3:0]  v;     // {space_n, rom_sel_n, ctl_sel_n, fb_sel_n}
        logic [31:0] a;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] haddr_hi = '0;
    logic        as_n = 1'b1;
    logic        rd_wr = 1'b1;
    logic        mode32 = 1'b1;
    logic [3:0]  slot_id = 4'h9;
    logic        space_n, rom_sel_n, ctl_sel_n, fb_sel_n;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    pslot_decoder dut (
        .clk(clk), .rst_n(rst_n), .haddr_hi(haddr_hi), .as_n(as_n),
        .rd_wr(rd_wr), .mode32(mode32), .slot_id(slot_id),
        .space_n(space_n), .rom_sel_n(rom_sel_n),
        .ctl_sel_n(ctl_sel_n), .fb_sel_n(fb_sel_n)
    );

    function automatic logic [3:0] model(logic [31:0] a, logic s_n, logic rd,
                                         logic m32, logic [3:0] s);
        logic q, ok, hit, rom, ctl;
        logic [3:0] r;
        q   = !s_n && (m32 ? (a[31:28] >= 4'h6) : (a[23:20] >= 4'h6));
        ok  = (s >= 4'h9) && (s <= 4'hE);
        hit = m32 ? (a[31:28] == s && a[27:24] == 4'h0) : (a[23:20] == s);
        rom = m32 ? (a[23:16] == 8'hFF) : (a[19:16] == 4'hF);
        ctl = m32 ? (a[23:16] == 8'hFE) : (a[19:16] == 4'hE);
        r = 4'b1111;
        r[3] = !q;
        if (q && ok && hit) begin
            if (rom)      r[2] = !rd;
            else if (ctl) r[1] = 1'b0;
            else          r[0] = 1'b0;
        end
        return r;
    endfunction

    task automatic apply(logic [31:0] a, logic s_n, logic rd, logic m32,
                         logic [3:0] s, string tag);
        exp_t e;
        @(negedge clk);
        haddr_hi = a[31:16];
        as_n     = s_n;
        rd_wr    = rd;
        mode32   = m32;
        slot_id  = s;
        e.v = model(a, s_n, rd, m32, s);
        e.a = a;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares one cycle after each driven item
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ({space_n, rom_sel_n, ctl_sel_n, fb_sel_n} !== e.v) begin
                errors++;
                $display("FAIL %s addr=%h actual=%b expected=%b", e.tag, e.a,
                         {space_n, rom_sel_n, ctl_sel_n, fb_sel_n}, e.v);
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs high during reset, even with a hitting address
        haddr_hi = 16'h90FF; as_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if ({space_n, rom_sel_n, ctl_sel_n, fb_sel_n} !== 4'b1111) begin
            errors++;
            $display("FAIL R1 actual=%b expected=1111",
                     {space_n, rom_sel_n, ctl_sel_n, fb_sel_n});
        end
        as_n = 1'b1;
        rst_n = 1'b1;

        // 32-bit mode, slot 9
        apply(32'h9000_0000, 0, 1, 1, 4'h9, "R5 R9 window base");
        apply(32'h90FF_0000, 0, 1, 1, 4'h9, "R7 rom first");
        apply(32'h90FF_FFFF, 0, 1, 1, 4'h9, "R7 rom last");
        apply(32'h90FE_FFFF, 0, 1, 1, 4'h9, "R8 ctrl last");
        apply(32'h90FE_0000, 0, 1, 1, 4'h9, "R8 ctrl first");
        apply(32'h90FD_FFFF, 0, 1, 1, 4'h9, "R9 fb top");
        apply(32'h91FF_0000, 0, 1, 1, 4'h9, "R5 alias byte");
        apply(32'hA0FF_0000, 0, 1, 1, 4'h9, "R5 other slot");
        apply(32'h5FFF_FFFF, 0, 1, 1, 4'h9, "R2 below space");
        apply(32'h6000_0000, 0, 1, 1, 4'h9, "R2 space edge");
        apply(32'hFFFF_FFFF, 0, 1, 1, 4'h9, "R2 space top");
        apply(32'h90FF_0000, 1, 1, 1, 4'h9, "R4 strobe high");
        apply(32'h90FE_0000, 0, 1, 1, 4'h9, "R12 select");
        apply(32'h90FF_0000, 0, 0, 1, 4'h9, "R10 rom write");
        apply(32'h90FE_0000, 0, 0, 1, 4'h9, "R10 ctrl write");
        apply(32'h9012_0000, 0, 0, 1, 4'h9, "R10 fb write");
        apply(32'hE0FF_0000, 0, 1, 1, 4'hE, "R11 slot 14");
        apply(32'h80FF_0000, 0, 1, 1, 4'h8, "R11 slot 8");
        apply(32'hF000_0000, 0, 1, 1, 4'hF, "R11 slot 15");

        // 24-bit mode, slot 11
        apply(32'h00B0_0000, 0, 1, 0, 4'hB, "R6 R3 R9 window base");
        apply(32'h12BF_0000, 0, 1, 0, 4'hB, "R6 R7 rom upper ignored");
        apply(32'h00BF_FFFF, 0, 1, 0, 4'hB, "R7 rom last");
        apply(32'h00BE_FFFF, 0, 1, 0, 4'hB, "R8 ctrl last");
        apply(32'hFFBE_0000, 0, 1, 0, 4'hB, "R8 ctrl first");
        apply(32'h00BD_FFFF, 0, 1, 0, 4'hB, "R9 fb top");
        apply(32'h00AF_0000, 0, 1, 0, 4'hB, "R6 other slot");
        apply(32'hFF50_0000, 0, 1, 0, 4'hB, "R3 upper ignored");
        apply(32'h0060_0000, 0, 1, 0, 4'hB, "R3 space edge");
        apply(32'h00BF_0000, 0, 0, 0, 4'hB, "R10 rom write 24");
        apply(32'h00BF_0000, 1, 1, 0, 4'hB, "R4 strobe high 24");

        @(negedge clk);
        as_n = 1'b1;
        while (q.size() > 0) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule